// File: doc/BRIEF.md
# Error Interrupt Status Unit

This unit collects six error event pulses from a link controller and holds each one in a sticky status bit until software clears it. Each bit can be enabled for interrupt delivery on its own. The unit drives one error interrupt, which is the OR of all enabled pending bits. It also drives a separate fatal indication, which covers only the fatal class of events. Detecting the errors is not part of this unit; it only records them.

Software reaches the unit through a small register port. The raw view shows every recorded event, whether or not it is enabled. The masked view shows only the enabled events, and writing ones to it clears the matching recorded bits. The enable mask is changed through two addresses: one sets enable bits and the other clears them, so no read-modify-write is needed.

The request side uses valid/ready. `req_ready` is always high, so a request is taken in every cycle in which `req_valid` is high. A read returns its data exactly one cycle after it is accepted. The response has no back-pressure, and writes produce no response.

Top module: `err_irq_unit`

## Requirements
- R1: After reset, all recorded bits and all enable bits are zero, and `err_irq`, `err_fatal` and `rsp_valid` are low.
- R2: Event inputs use this bit encoding: bit 0 system, bit 1 fatal, bit 2 non-fatal, bit 3 correctable, bit 4 tag-lookup fatal, bit 5 end-to-end CRC. A one-cycle pulse on a bit sets the matching recorded bit on the next clock edge. The bit then stays set until software clears it.
- R3: A read of address 0x1C0 returns the recorded bits in data bits 5:0. A read of 0x1C4 returns recorded AND enable. Data bits 31:6 always read as zero.
- R4: Writing to 0x1C8 sets every enable bit whose data bit is 1. Writing to 0x1CC clears every enable bit whose data bit is 1. A read of either address returns the enable mask in bits 5:0.
- R5: Writing to 0x1C4 clears every recorded bit whose data bit is 1 and leaves the other recorded bits unchanged.
- R6: If an event pulse and a clear of the same bit arrive in the same cycle, the event wins and the bit stays set.
- R7: `err_irq` is high exactly when recorded AND enable is nonzero. It follows the register state with no extra register stage.
- R8: `err_fatal` is high exactly when recorded AND enable has bit 1 or bit 4 set. A pending fatal-class bit whose enable is clear does not raise it.
- R9: Writes to 0x1C0 and to unmapped addresses change no state. Reads of unmapped addresses return zero.
- R10: `req_ready` is always 1. `rsp_valid` is high for exactly one cycle, in the cycle after an accepted read, and stays low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| err_evt | input | 6 | Error event pulses, one bit per class |
| err_irq | output | 1 | Error interrupt |
| err_fatal | output | 1 | Fatal-class interrupt |

## Verification
The bench drives an event and a clear of the same bit in one cycle. A design in which the clear wins would lose that event and read back zero. It writes ones to the raw-status address and to an unmapped address. A design that treats the raw view as write-1-to-clear, or that decodes addresses loosely, would drop recorded bits or change the enables. It also records a fatal-class event while that bit's enable is off and checks that the fatal output stays low. A design that built the fatal output from the raw bits would raise it too early. Finally, it sets all 32 enable bits at once and checks that bits 31:6 still read as zero.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;

  // Register selects produced by the address decoder
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_RAW  = 3'd1,
    SEL_MSK  = 3'd2,
    SEL_ENS  = 3'd3,
    SEL_ENC  = 3'd4
  } reg_sel_e;

  localparam int          EVT_W_DEF      = 6;
  localparam logic [11:0] OFS_RAW_DEF    = 12'h1C0;
  localparam logic [11:0] OFS_MSK_DEF    = 12'h1C4;
  localparam logic [11:0] OFS_ENS_DEF    = 12'h1C8;
  localparam logic [11:0] OFS_ENC_DEF    = 12'h1CC;
  localparam logic [5:0]  FATAL_MASK_DEF = 6'b01_0010;

endpackage

// File: rtl/err_reg_decode.sv
module err_reg_decode
  import err_irq_pkg::*;
#(
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] OFS_RAW = ADDR_W'(OFS_RAW_DEF),
  parameter logic [ADDR_W-1:0] OFS_MSK = ADDR_W'(OFS_MSK_DEF),
  parameter logic [ADDR_W-1:0] OFS_ENS = ADDR_W'(OFS_ENS_DEF),
  parameter logic [ADDR_W-1:0] OFS_ENC = ADDR_W'(OFS_ENC_DEF)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == OFS_RAW)      sel_o = SEL_RAW;
    else if (addr_i == OFS_MSK) sel_o = SEL_MSK;
    else if (addr_i == OFS_ENS) sel_o = SEL_ENS;
    else if (addr_i == OFS_ENC) sel_o = SEL_ENC;
  end

endmodule

// File: rtl/err_status_bank.sv
module err_status_bank #(
  parameter int EVT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] raw_o
);

  logic [EVT_W-1:0] raw_q;

  // One sticky bit per event; a new event has priority over a clear
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        raw_q[i] <= 1'b0;
      else if (evt_i[i]) raw_q[i] <= 1'b1;
      else if (clr_i[i]) raw_q[i] <= 1'b0;
    end
  end

  assign raw_o = raw_q;

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i))); // R6

  AST_W1C_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((raw_q & $past(clr_i) & ~$past(evt_i)) == '0)); // R5

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i == '0) && (clr_i == '0)) |=> $stable(raw_q)); // R2

endmodule

// File: rtl/err_enable_bank.sv
module err_enable_bank #(
  parameter int EVT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] en_o
);

  logic [EVT_W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_i) & ~clr_i;
  end

  assign en_o = en_q;

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i != '0) && (clr_i == '0)) |=> ((en_q & $past(set_i)) == $past(set_i))); // R4

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((en_q & $past(clr_i)) == '0)); // R4

endmodule

// File: rtl/err_irq_out.sv
module err_irq_out #(
  parameter int               EVT_W      = 6,
  parameter logic [EVT_W-1:0] FATAL_MASK = EVT_W'(6'b01_0010)
) (
  input  logic [EVT_W-1:0] raw_i,
  input  logic [EVT_W-1:0] en_i,
  output logic [EVT_W-1:0] masked_o,
  output logic             irq_o,
  output logic             fatal_o
);

  always_comb begin
    masked_o = raw_i & en_i;
    irq_o    = |masked_o;
    fatal_o  = |(masked_o & FATAL_MASK);
  end

endmodule

// File: rtl/err_irq_unit.sv
module err_irq_unit
  import err_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int EVT_W  = EVT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [EVT_W-1:0]  err_evt,
  output logic              err_irq,
  output logic              err_fatal
);

  localparam int PAD_W = DATA_W - EVT_W;
  localparam logic [EVT_W-1:0] FMASK = EVT_W'(FATAL_MASK_DEF);

  reg_sel_e         sel;
  logic             wr_fire, rd_fire;
  logic [EVT_W-1:0] wbits;
  logic [EVT_W-1:0] st_clr, en_set, en_clr;
  logic [EVT_W-1:0] raw, en, masked;
  logic [EVT_W-1:0] rd_mux;
  logic             unused_wdata;

  assign req_ready    = 1'b1;
  assign wr_fire      = req_valid && req_write;
  assign rd_fire      = req_valid && !req_write;
  assign wbits        = req_wdata[EVT_W-1:0];
  assign unused_wdata = ^req_wdata[DATA_W-1:EVT_W];

  err_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (req_addr),
    .sel_o  (sel)
  );

  assign st_clr = (wr_fire && sel == SEL_MSK) ? wbits : '0;
  assign en_set = (wr_fire && sel == SEL_ENS) ? wbits : '0;
  assign en_clr = (wr_fire && sel == SEL_ENC) ? wbits : '0;

  err_status_bank #(.EVT_W(EVT_W)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (err_evt),
    .clr_i (st_clr),
    .raw_o (raw)
  );

  err_enable_bank #(.EVT_W(EVT_W)) u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (en_set),
    .clr_i (en_clr),
    .en_o  (en)
  );

  err_irq_out #(.EVT_W(EVT_W), .FATAL_MASK(FMASK)) u_out (
    .raw_i    (raw),
    .en_i     (en),
    .masked_o (masked),
    .irq_o    (err_irq),
    .fatal_o  (err_fatal)
  );

  always_comb begin
    unique case (sel)
      SEL_RAW:          rd_mux = raw;
      SEL_MSK:          rd_mux = masked;
      SEL_ENS, SEL_ENC: rd_mux = en;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= {{PAD_W{1'b0}}, rd_mux};
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid); // R10

  AST_NO_RSP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rsp_valid); // R10

  AST_FATAL_IN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |-> err_irq); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DATA_W-1:EVT_W] == '0)); // R3

  AST_RAW_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && sel == SEL_RAW && err_evt == '0) |=> ($stable(raw) && $stable(en))); // R9

endmodule

// File: tb/err_irq_unit_test.sv
`timescale 1ns/1ps
module err_irq_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [5:0]  err_evt = '0;
  logic        err_irq;
  logic        err_fatal;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  err_irq_unit uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_evt(err_evt), .err_irq(err_irq), .err_fatal(err_fatal)
  );

  // op: 0 = event pulse (data holds the event bits), 1 = write, 2 = read
  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        irq;
    logic        fat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 12'h1C0, 32'h0,        32'h00, 1'b0, 1'b0, 4'd1},  // R1 raw empty
    '{2'd0, 12'h000, 32'h09,       32'h00, 1'b0, 1'b0, 4'd2},  // R2 system+correctable
    '{2'd2, 12'h1C0, 32'h0,        32'h09, 1'b0, 1'b0, 4'd3},  // R3 raw view
    '{2'd2, 12'h1C4, 32'h0,        32'h00, 1'b0, 1'b0, 4'd3},  // R3 masked empty
    '{2'd1, 12'h1C8, 32'h08,       32'h00, 1'b1, 1'b0, 4'd7},  // R7 enable bit3
    '{2'd2, 12'h1C4, 32'h0,        32'h08, 1'b1, 1'b0, 4'd3},
    '{2'd2, 12'h1CC, 32'h0,        32'h08, 1'b1, 1'b0, 4'd4},  // R4 enable readback
    '{2'd0, 12'h000, 32'h02,       32'h00, 1'b1, 1'b0, 4'd8},  // R8 fatal not enabled
    '{2'd1, 12'h1C8, 32'h12,       32'h00, 1'b1, 1'b1, 4'd8},  // R8 enable fatal class
    '{2'd2, 12'h1C4, 32'h0,        32'h0A, 1'b1, 1'b1, 4'd3},
    '{2'd1, 12'h1CC, 32'h02,       32'h00, 1'b1, 1'b0, 4'd4},  // R4 clear enable
    '{2'd0, 12'h000, 32'h10,       32'h00, 1'b1, 1'b1, 4'd8},  // R8 tag-lookup fatal
    '{2'd1, 12'h1C4, 32'h18,       32'h00, 1'b0, 1'b0, 4'd5},  // R5 w1c
    '{2'd2, 12'h1C0, 32'h0,        32'h03, 1'b0, 1'b0, 4'd5},
    '{2'd1, 12'h1C0, 32'h3F,       32'h00, 1'b0, 1'b0, 4'd9},  // R9 raw write ignored
    '{2'd2, 12'h1C0, 32'h0,        32'h03, 1'b0, 1'b0, 4'd9},
    '{2'd1, 12'h100, 32'h3F,       32'h00, 1'b0, 1'b0, 4'd9},  // R9 unmapped write
    '{2'd2, 12'h1C8, 32'h0,        32'h18, 1'b0, 1'b0, 4'd9},
    '{2'd2, 12'h100, 32'h0,        32'h00, 1'b0, 1'b0, 4'd9},  // R9 unmapped read
    '{2'd1, 12'h1C8, 32'hFFFFFFFF, 32'h00, 1'b1, 1'b1, 4'd4},
    '{2'd2, 12'h1C8, 32'h0,        32'h3F, 1'b1, 1'b1, 4'd3},  // R3 upper zero
    '{2'd1, 12'h1C4, 32'h3F,       32'h00, 1'b0, 1'b0, 4'd5}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one request and/or event at a negedge; return at the next negedge
  task automatic apply(input logic [1:0] op, input logic [11:0] addr,
                       input logic [31:0] data, input logic [5:0] evt);
    req_valid = (op != 2'd0);
    req_write = (op == 2'd1);
    req_addr  = addr;
    req_wdata = data;
    err_evt   = ((op == 2'd0) ? data[5:0] : 6'h0) | evt;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    err_evt   = '0;
  endtask

  task automatic rd(input logic [11:0] addr, input logic [31:0] exp, input string req);
    apply(2'd2, addr, 32'h0, 6'h0);
    chk(rsp_valid === 1'b1, req, 32'(rsp_valid), 32'h1, "rsp_valid");
    chk(rsp_rdata === exp, req, rsp_rdata, exp, "read data");
  endtask

  initial begin
    @(negedge clk);
    // R1: outputs quiet while in reset
    chk(err_irq === 1'b0 && err_fatal === 1'b0 && rsp_valid === 1'b0, "R1",
        {29'h0, err_irq, err_fatal, rsp_valid}, 32'h0, "outputs in reset");
    chk(req_ready === 1'b1, "R10", 32'(req_ready), 32'h1, "req_ready");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].addr, VEC[i].data, 6'h0);
      if (VEC[i].op == 2'd2) begin
        chk(rsp_valid === 1'b1, $sformatf("R%0d", VEC[i].req), 32'(rsp_valid), 32'h1,
            $sformatf("vec %0d rsp_valid", i));
        chk(rsp_rdata === VEC[i].exp, $sformatf("R%0d", VEC[i].req), rsp_rdata, VEC[i].exp,
            $sformatf("vec %0d read", i));
      end else begin
        chk(rsp_valid === 1'b0, "R10", 32'(rsp_valid), 32'h0,
            $sformatf("vec %0d no response", i));
      end
      chk(err_irq === VEC[i].irq, $sformatf("R%0d", VEC[i].req), 32'(err_irq),
          32'(VEC[i].irq), $sformatf("vec %0d irq", i));
      chk(err_fatal === VEC[i].fat, $sformatf("R%0d", VEC[i].req), 32'(err_fatal),
          32'(VEC[i].fat), $sformatf("vec %0d fatal", i));
    end

    // R6: event and clear of the same bit in one cycle; bit 0 is cleared alone
    apply(2'd0, 12'h0, 32'h01, 6'h0);
    apply(2'd1, 12'h1C4, 32'h21, 6'h20);
    rd(12'h1C0, 32'h20, "R6");
    // R7: irq still high with every enable on and bit 5 pending
    chk(err_irq === 1'b1 && err_fatal === 1'b0, "R7",
        {30'h0, err_irq, err_fatal}, 32'h2, "irq after collision");

    // R10: the response lasts one cycle only
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10", 32'(rsp_valid), 32'h0, "response one cycle");

    // R2: a pulse with no enable still records the event; a later clear removes it
    apply(2'd1, 12'h1CC, 32'h3F, 6'h0);
    apply(2'd0, 12'h0, 32'h04, 6'h0);
    chk(err_irq === 1'b0, "R2", 32'(err_irq), 32'h0, "disabled event no irq");
    repeat (3) @(negedge clk);
    rd(12'h1C0, 32'h24, "R2");

    // R1: reset in mid-run drops recorded and enable state
    apply(2'd1, 12'h1C8, 32'h3F, 6'h0);
    chk(err_irq === 1'b1 && err_fatal === 1'b0, "R8", {30'h0, err_irq, err_fatal},
        32'h2, "non-fatal bits only");
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(err_irq === 1'b0 && err_fatal === 1'b0, "R1", {30'h0, err_irq, err_fatal},
        32'h0, "outputs after reset");
    rd(12'h1C0, 32'h0, "R1");
    rd(12'h1C8, 32'h0, "R1");

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule